// File: doc/BRIEF.md
# SPI flash command engine

This block is a register-programmed SPI master for serial flash parts. Software places up to four command bytes in a transmit register. It then writes a control word that carries the byte counts, a bank number and a trigger bit. The engine runs one SPI transaction inside a chip-select frame: it shifts the command bytes out, then clocks in the requested number of response bytes. The response is packed into a receive register, and a sticky completion flag in the status register reports that the frame has closed.

Two shortcut trigger bits in the control word need no transmit data. One reads the flash status byte into the status register. The other issues the write-enable opcode. The serial clock is a fixed division of the system clock, and the bus runs in SPI mode 3 only. Register reads are combinational and have no side effects.

Top module: `sfce_top`

## Requirements
- R1: After reset every chip select is high, the serial clock is high, and the control, status, transmit and receive registers all read zero.
- R2: Mode 3 timing. The serial clock idles high and each phase lasts HALF_DIV system clocks. The MOSI line changes only while the clock is low, and MISO is sampled on the rising edge. Bits go out and come in most significant bit first.
- R3: Writing the control word (offset 0x04) with bit 7 set starts a frame. The frame sends the number of bytes in bits [2:0], taken from the transmit register starting at bits [7:0]. It then clocks the number of bytes in bits [6:4] while driving 0x00. A count above 4 acts as 4. A trigger with both counts at zero starts no frame.
- R4: After a bit-7 frame, the receive register (offset 0x10, read-only) holds the first response byte in bits [7:0], the next in bits [15:8], and so on. Bytes that were not received read as zero. The register changes only when such a frame completes.
- R5: Control bit 10 sends opcode 0x05, receives one byte, and puts it in status bits [7:0]. The receive register is left unchanged.
- R6: Control bit 11 sends the single opcode byte 0x06, receives nothing, and leaves the receive register and status bits [7:0] unchanged.
- R7: When several trigger bits are set together, bit 10 wins over bit 11, and bit 11 wins over bit 7.
- R8: Control bits [13:12] choose which chip-select line goes low. At most one line is low at a time, and it stays low without change for the whole frame, including the receive bytes.
- R9: Status bit 8 sets after the chip select has returned high at the end of every frame. Writing the status register (offset 0x08) with bit 8 at zero clears it. Writing with bit 8 at one leaves it set.
- R10: A control-word write that arrives while a frame is in progress is ignored completely. It starts no frame and changes no field.
- R11: The control word reads back the effective counts in bits [2:0] and [6:4] and the bank in bits [13:12]. Trigger bits read as zero. The transmit register (offset 0x0C) reads back what was written. Offset 0x00 and unused offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | AW | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| cs_no | output | NUM_BANKS | Chip selects, active low, one per bank |

## Verification
The bench builds the engine with HALF_DIV=3, so every bit takes six system clocks and the divider must count an odd number of phases. NUM_BANKS is 4, so the bench can drive each chip-select line in turn and confirm that only the chosen one falls. A flash model in the bench drives a known response stream that depends on byte position. This lets it check zero-fill and byte packing for every receive count. It also checks that a trigger written while a frame is running does not launch a second frame.

// File: rtl/sfce_pkg.sv
`timescale 1ns/1ps
package sfce_pkg;
  localparam int NB = 4;   // bytes per data word
  localparam int CW = 3;   // byte count field width
  localparam int TW = 4;   // frame byte index width

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam int W_CTRL = 1;
  localparam int W_STAT = 2;
  localparam int W_TXD  = 3;
  localparam int W_RXD  = 4;

  localparam int B_SEND = 7;
  localparam int B_RDSR = 10;
  localparam int B_WREN = 11;
  localparam int B_BANK = 12;
  localparam int B_DONE = 8;

  typedef enum logic [1:0] {K_SEND, K_RDSR, K_WREN} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_DONE} sh_state_e;

  function automatic logic [CW-1:0] clamp_cnt(input logic [CW-1:0] v);
    return (v > CW'(NB)) ? CW'(NB) : v;
  endfunction
endpackage

// File: rtl/sfce_shifter.sv
`timescale 1ns/1ps
module sfce_shifter
  import sfce_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [8*NB-1:0]   tx_word_i,
  input  logic [CW-1:0]     tx_cnt_i,
  input  logic [CW-1:0]     rx_cnt_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              frame_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [8*NB-1:0]   rx_word_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LOAD = DW'(HALF_DIV - 1);

  sh_state_e        state_q;
  logic [DW-1:0]    div_q;
  logic [2:0]       bit_q;
  logic [TW-1:0]    byte_q;
  logic [8*NB-1:0]  tx_q;
  logic [CW-1:0]    ntx_q, nrx_q;
  logic [7:0]       sh_rx_q;
  logic [8*NB-1:0]  rx_q;

  logic [TW-1:0] total, rx_idx;
  logic [7:0]    cur_byte;

  assign total  = TW'(ntx_q) + TW'(nrx_q);
  assign rx_idx = byte_q - TW'(ntx_q);

  always_comb begin
    cur_byte = '0;
    for (int k = 0; k < NB; k++)
      if (byte_q == TW'(k)) cur_byte = tx_q[8*k +: 8];
    if (byte_q >= TW'(ntx_q)) cur_byte = '0;  // dummy bytes during receive
  end

  assign frame_o   = (state_q == S_LEAD) || (state_q == S_LOW) || (state_q == S_HIGH);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign sck_o     = (state_q != S_LOW);
  assign mosi_o    = frame_o & cur_byte[3'd7 - bit_q];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      tx_q    <= '0;
      ntx_q   <= '0;
      nrx_q   <= '0;
      sh_rx_q <= '0;
      rx_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          tx_q    <= tx_word_i;
          ntx_q   <= tx_cnt_i;
          nrx_q   <= rx_cnt_i;
          rx_q    <= '0;
          bit_q   <= '0;
          byte_q  <= '0;
          div_q   <= DIV_LOAD;
          state_q <= S_LEAD;
        end
        S_LEAD: begin
          if (div_q == '0) begin
            div_q   <= DIV_LOAD;
            state_q <= S_LOW;
          end else div_q <= div_q - 1'b1;
        end
        S_LOW: begin
          if (div_q == '0) begin
            div_q   <= DIV_LOAD;
            sh_rx_q <= {sh_rx_q[6:0], miso_i};  // rising edge sample
            state_q <= S_HIGH;
          end else div_q <= div_q - 1'b1;
        end
        S_HIGH: begin
          if (div_q == '0) begin
            div_q <= DIV_LOAD;
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (byte_q >= TW'(ntx_q))
                for (int k = 0; k < NB; k++)
                  if (rx_idx == TW'(k)) rx_q[8*k +: 8] <= sh_rx_q;
              if (byte_q == total - 1'b1) state_q <= S_DONE;
              else begin
                byte_q  <= byte_q + 1'b1;
                state_q <= S_LOW;
              end
            end else begin
              bit_q   <= bit_q + 1'b1;
              state_q <= S_LOW;
            end
          end else div_q <= div_q - 1'b1;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfce_regs.sv
`timescale 1ns/1ps
module sfce_regs
  import sfce_pkg::*;
#(
  parameter int AW = 5,
  parameter int BW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [8*NB-1:0]  rx_word_i,
  output logic             start_o,
  output logic [8*NB-1:0]  tx_word_o,
  output logic [CW-1:0]    tx_cnt_o,
  output logic [CW-1:0]    rx_cnt_o,
  output logic [BW-1:0]    bank_o,
  output logic             done_flag_o
);
  localparam int WW = AW - 2;

  logic [WW-1:0]   word;
  logic            wr, ctrl_wr;
  logic [CW-1:0]   txc_q, rxc_q, tx_eff, rx_eff;
  logic [BW-1:0]   bank_q;
  logic [8*NB-1:0] txd_q, rxd_q;
  logic [7:0]      stat_q;
  logic            done_q;
  kind_e           kind_q, kind_n;

  assign word    = addr_i[AW-1:2];
  assign wr      = req_i & we_i;
  assign ctrl_wr = wr && (word == WW'(W_CTRL)) && !busy_i;
  assign tx_eff  = clamp_cnt(wdata_i[2:0]);
  assign rx_eff  = clamp_cnt(wdata_i[6:4]);

  // launch decode, priority: read-status, write-enable, send
  always_comb begin
    start_o   = 1'b0;
    kind_n    = K_SEND;
    tx_word_o = txd_q;
    tx_cnt_o  = tx_eff;
    rx_cnt_o  = rx_eff;
    if (ctrl_wr) begin
      if (wdata_i[B_RDSR]) begin
        start_o   = 1'b1;
        kind_n    = K_RDSR;
        tx_word_o = {{(8*NB-8){1'b0}}, OP_RDSR};
        tx_cnt_o  = CW'(1);
        rx_cnt_o  = CW'(1);
      end else if (wdata_i[B_WREN]) begin
        start_o   = 1'b1;
        kind_n    = K_WREN;
        tx_word_o = {{(8*NB-8){1'b0}}, OP_WREN};
        tx_cnt_o  = CW'(1);
        rx_cnt_o  = '0;
      end else if (wdata_i[B_SEND] && ((tx_eff != '0) || (rx_eff != '0))) begin
        start_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txc_q  <= '0;
      rxc_q  <= '0;
      bank_q <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      stat_q <= '0;
      done_q <= 1'b0;
      kind_q <= K_SEND;
    end else begin
      if (ctrl_wr) begin
        txc_q  <= tx_eff;
        rxc_q  <= rx_eff;
        bank_q <= wdata_i[B_BANK +: BW];
      end
      if (start_o) kind_q <= kind_n;
      if (wr && (word == WW'(W_TXD))) txd_q <= wdata_i;
      if (done_i) begin
        if (kind_q == K_SEND) rxd_q  <= rx_word_i;
        if (kind_q == K_RDSR) stat_q <= rx_word_i[7:0];
      end
      if (done_i) done_q <= 1'b1;
      else if (wr && (word == WW'(W_STAT)) && !wdata_i[B_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (word)
      WW'(W_CTRL): begin
        rdata_o[2:0]           = txc_q;
        rdata_o[6:4]           = rxc_q;
        rdata_o[B_BANK +: BW]  = bank_q;
      end
      WW'(W_STAT): rdata_o = {23'b0, done_q, stat_q};
      WW'(W_TXD):  rdata_o = txd_q;
      WW'(W_RXD):  rdata_o = rxd_q;
      default:     rdata_o = '0;
    endcase
  end

  assign bank_o      = bank_q;
  assign done_flag_o = done_q;
endmodule

// File: rtl/sfce_csdec.sv
`timescale 1ns/1ps
module sfce_csdec #(
  parameter int NUM_BANKS = 4,
  parameter int BW = 2
) (
  input  logic [BW-1:0]        bank_i,
  input  logic                 frame_i,
  output logic [NUM_BANKS-1:0] cs_no
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign cs_no[b] = ~(frame_i && (bank_i == BW'(b)));
  end
endmodule

// File: rtl/sfce_top.sv
`timescale 1ns/1ps
module sfce_top
  import sfce_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int NUM_BANKS = 4,
  parameter int AW        = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 sck_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic [NUM_BANKS-1:0] cs_no
);
  localparam int BW = $clog2(NUM_BANKS);

  logic            start, busy, frame, sh_done, done_flag;
  logic [8*NB-1:0] tx_word, rx_word;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [BW-1:0]   bank;

  sfce_regs #(.AW(AW), .BW(BW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(sh_done), .rx_word_i(rx_word),
    .start_o(start), .tx_word_o(tx_word), .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt),
    .bank_o(bank), .done_flag_o(done_flag)
  );

  sfce_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_word_i(tx_word),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .miso_i,
    .busy_o(busy), .frame_o(frame), .sck_o, .mosi_o,
    .done_o(sh_done), .rx_word_o(rx_word)
  );

  sfce_csdec #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_cs (
    .bank_i(bank), .frame_i(frame), .cs_no
  );
endmodule

// File: rtl/sfce_chk.sv
`timescale 1ns/1ps
module sfce_chk #(
  parameter int NUM_BANKS = 4,
  parameter int AW = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [AW-1:0]        addr_i,
  input logic [31:0]          wdata_i,
  input logic                 sck_o,
  input logic                 mosi_o,
  input logic [NUM_BANKS-1:0] cs_no,
  input logic                 done_flag,
  input logic                 sh_done
);
  logic idle;
  assign idle = &cs_no;

  // R8
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R8
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !(&$past(cs_no))) |-> (cs_no == $past(cs_no)));

  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> sck_o);

  // R2
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o) && !idle && !(&$past(cs_no))) |-> $stable(mosi_o));

  // R9
  done_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag) |-> (idle && (&$past(cs_no))));

  // R9
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i[AW-1:2] == (AW-2)'(2)) && !wdata_i[8] && !sh_done)
    |=> !done_flag);
endmodule

bind sfce_top sfce_chk #(.NUM_BANKS(NUM_BANKS), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .sck_o(sck_o), .mosi_o(mosi_o),
  .cs_no(cs_no), .done_flag(done_flag), .sh_done(sh_done)
);

// File: tb/sim_sfce_top.sv
`timescale 1ns/1ps
module sim_sfce_top;
  localparam int NBK = 4;
  localparam int AWB = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AWB-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, mosi, miso = 1'b0;
  logic [NBK-1:0] cs_n;

  sfce_top #(.HALF_DIV(3), .NUM_BANKS(NBK), .AW(AWB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  // flash model
  logic cs_act;
  assign cs_act = ~&cs_n;
  int rises = 0, frames = 0, frame_bank = -1;
  logic [7:0] cur = '0;
  logic [7:0] cap [8];

  function automatic logic [7:0] resp_byte(input int k);
    return 8'h3C ^ 8'(k * 37 + 11);
  endfunction

  always @(posedge cs_act) begin
    rises = 0;
    frames++;
    for (int b = 0; b < NBK; b++) if (!cs_n[b]) frame_bank = b;
    for (int i = 0; i < 8; i++) cap[i] = 8'h00;
  end
  always @(posedge sck) if (cs_act) begin
    cur = {cur[6:0], mosi};
    rises++;
    if (rises % 8 == 0) cap[rises/8 - 1] = cur;
  end
  always @(negedge sck) if (cs_act) begin
    logic [7:0] rb;
    rb = resp_byte(rises / 8);
    miso = rb[7 - (rises % 8)];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AWB'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = AWB'(a);
    #1 d = rdata;
  endtask

  task automatic run_cmd(input logic [31:0] c2, output bit seen);
    logic [31:0] d;
    wr(8'h08, 32'h0);
    wr(8'h04, c2);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd(8'h08, d);
      if (d[8]) seen = 1;
    end
  endtask

  // {tx word, control word}
  localparam logic [47:0] VEC [4] = '{
    {32'h563412D8, 16'h0084},
    {32'h0000009F, 16'h10B1},
    {32'h00000B03, 16'h20C2},
    {32'h0000CAFE, 16'h30A0}
  };

  initial begin
    #600000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, rx_prev, stat_prev, exp;
    bit seen;
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == '1 && sck == 1'b1, "R1 pins", {cs_n, 3'b0, sck}, 32'hF1);
    rd(8'h04, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(8'h08, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h0C, d); chk(d == 0, "R1 txd", d, 0);
    rd(8'h10, d); chk(d == 0, "R1 rxd", d, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R8 table walk
    for (int v = 0; v < 4; v++) begin
      logic [31:0] tw; logic [15:0] c2; int ntx, nrx, bk; bit ok;
      tw = VEC[v][47:16]; c2 = VEC[v][15:0];
      ntx = c2[2:0]; nrx = c2[6:4]; bk = c2[13:12];
      wr(8'h0C, tw);
      f0 = frames;
      run_cmd({16'h0, c2}, seen);
      chk(seen, "R9 done set", {31'b0, seen}, 1);
      chk(frames == f0 + 1, "R3 one frame", frames, f0 + 1);
      chk(frame_bank == bk, "R8 bank", frame_bank, bk);
      chk(rises == 8 * (ntx + nrx), "R2 edges", rises, 8 * (ntx + nrx));
      ok = 1;
      for (int i = 0; i < ntx + nrx; i++) begin
        logic [7:0] e;
        e = (i < ntx) ? tw[8*i +: 8] : 8'h00;
        if (cap[i] !== e) ok = 0;
      end
      chk(ok, "R3 mosi bytes", {24'b0, cap[0]}, {24'b0, tw[7:0]});
      exp = 0;
      for (int j = 0; j < nrx; j++) exp[8*j +: 8] = resp_byte(ntx + j);
      rd(8'h10, d); chk(d == exp, "R4 rx packing", d, exp);
      chk(cs_n == '1 && sck, "R2 idle after", {cs_n, 3'b0, sck}, 32'hF1);
    end
    rd(8'h04, d); chk(d == 32'h3020, "R11 ctrl readback", d, 32'h3020);
    rd(8'h0C, d); chk(d == 32'h0000CAFE, "R11 txd readback", d, 32'hCAFE);
    rd(8'h00, d); chk(d == 0, "R11 offset0", d, 0);
    rd(8'h14, d); chk(d == 0, "R11 unused", d, 0);

    // R9 done flag write semantics
    wr(8'h08, 32'h100); rd(8'h08, d); chk(d[8] == 1'b1, "R9 write one keeps", d, 32'h100);
    wr(8'h08, 32'h0);   rd(8'h08, d); chk(d[8] == 1'b0, "R9 clear", d, 0);

    // R5 read status
    rd(8'h10, rx_prev);
    wr(8'h0C, 32'hFFFFFFFF);
    run_cmd(32'h2400, seen);
    chk(seen && cap[0] == 8'h05 && rises == 16, "R5 opcode", {cap[0], 8'b0, 16'(rises)}, {8'h05, 8'h0, 16'd16});
    chk(frame_bank == 2, "R8 rdsr bank", frame_bank, 2);
    rd(8'h08, d); chk(d[7:0] == resp_byte(1), "R5 status byte", d[7:0], resp_byte(1));
    stat_prev = {24'b0, d[7:0]};
    rd(8'h10, d); chk(d == rx_prev, "R5 rx unchanged", d, rx_prev);

    // R6 write enable
    run_cmd(32'h1800, seen);
    chk(seen && cap[0] == 8'h06 && rises == 8, "R6 opcode", {cap[0], 8'b0, 16'(rises)}, {8'h06, 8'h0, 16'd8});
    rd(8'h08, d); chk(d[7:0] == stat_prev[7:0], "R6 status unchanged", d[7:0], stat_prev);
    rd(8'h10, d); chk(d == rx_prev, "R6 rx unchanged", d, rx_prev);

    // R7 priority
    run_cmd(32'h0C91, seen);
    chk(seen && cap[0] == 8'h05 && rises == 16, "R7 priority", {cap[0], 8'b0, 16'(rises)}, {8'h05, 8'h0, 16'd16});
    run_cmd(32'h0891, seen);
    chk(seen && cap[0] == 8'h06 && rises == 8, "R7 wren over send", {cap[0], 8'b0, 16'(rises)}, {8'h06, 8'h0, 16'd8});

    // R3 clamp
    wr(8'h0C, 32'h44332211);
    run_cmd(32'h00F7, seen);
    chk(seen && rises == 64 && cap[3] == 8'h44, "R3 clamp", 32'(rises), 64);
    rd(8'h04, d); chk(d == 32'h44, "R11 clamp readback", d, 32'h44);

    // R3 zero-length ignored
    f0 = frames;
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0080);
    repeat (80) @(negedge clk);
    rd(8'h08, d);
    chk(frames == f0 && d[8] == 1'b0, "R3 zero length", {frames[15:0], 7'b0, d[8]}, {f0[15:0], 8'h0});

    // R10 trigger while busy
    f0 = frames;
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h00C4);
    repeat (10) @(negedge clk);
    wr(8'h04, 32'h3081);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin rd(8'h08, d); if (d[8]) seen = 1; end
    repeat (100) @(negedge clk);
    chk(seen && frames == f0 + 1, "R10 no second frame", frames, f0 + 1);
    chk(frame_bank == 0, "R10 bank kept", frame_bank, 0);
    rd(8'h04, d); chk(d == 32'h44, "R10 fields kept", d, 32'h44);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule